// File: doc/BRIEF.md
# Fuse Macro Register Read Port

This block lets software read a one-time-programmable fuse array by toggling the macro's control pins through a memory-mapped register. Software writes a 32-bit control word that holds the chip select (active low), strobe, load and program-disable pins, plus a 10-bit fuse byte address. A second register returns the addressed fuse byte. Reads are paced entirely by software. No handshake exists. Data is valid only while the strobe pin is high and the macro is in read mode.

A behavioural fuse array stands in for the real macro. It holds 1024 bytes, and its contents come from a parameter image at reset. Each byte is fetched with the same sequence:
1. Enter read mode with load and program-disable set and chip select low.
2. Place the address.
3. Raise strobe.
4. Read the data register.
5. Drop strobe.

Afterwards software returns the macro to standby.

Raising strobe in any other pin state has no effect on the fuse data. Instead it records a sticky error flag.

Top module: `fuse_regport`

## Requirements
- R1: After reset, the control register (offset 0x0) reads 0x0000_0009, which is chip select high and program-disable set with every other bit zero. The data register (offset 0x4) reads 0.
- R2: A control write stores bit 0 (chip select, active low), bit 1 (strobe), bit 2 (load), bit 3 (program-disable) and the fuse address in bits 15:6, and the same bits read back. Bits 4, 5 and 30:16 always read 0.
- R3: Read mode means load=1, program-disable=1 and chip select=0 together. When a control write leaves strobe high in read mode, the data register's bits 7:0 equal the fuse byte at the address in bits 15:6, readable in the first cycle after that write.
- R4: While strobe stays high in read mode, writing a new address makes the data register show the byte at the new address from the next cycle on.
- R5: Once strobe is cleared, or the macro is put in standby (control 0x0000_0009), the data register keeps the last byte fetched.
- R6: A control write with strobe set while chip select is high (standby) leaves the data register unchanged and sets the error flag at control bit 31.
- R7: A control write with strobe set while chip select is low but load or program-disable is clear leaves the data register unchanged and sets the error flag.
- R8: The error flag is sticky. A control write with bit 31 at 0 keeps it set, and a control write with bit 31 at 1 clears it.
- R9: When one control write both carries bit 31 = 1 and is itself an error strobe, the flag ends up set.
- R10: Data register bits 31:8 read 0. Writes to the data register are ignored. Offsets other than 0x0 and 0x4 read 0 and ignore writes.
- R11: Fuse byte a is bits 8a+7 down to 8a of the image parameter, valid for every address from 0 to 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also reloads the fuse image |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW (3) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read is active |

## Verification
A broken read-mode decode or address field shows on the data register at the first read after the strobe-raising write. That read falls one cycle after the write and sees either a stale byte or a byte from the wrong address. A lost or wrongly latched held byte appears at the first data read after strobe falls. An error flag with the wrong state is visible at the very next control read, so a missed set, a missed clear or a bad priority between the two shows up within one cycle. Wrong fuse contents show as soon as an affected address is strobed, which is why both ends and the middle of the array are fetched.

// File: rtl/fuse_regport_pkg.sv
package fuse_regport_pkg;

   // Pin bit positions inside the control word (decoded by software)
   localparam int PIN_CSN_BIT  = 0;
   localparam int PIN_STB_BIT  = 1;
   localparam int PIN_LOAD_BIT = 2;
   localparam int PIN_PGD_BIT  = 3;
   localparam int ERR_BIT      = 31;
   localparam int DATA_W       = 32;
   localparam int FUSE_BYTE_W  = 8;

   typedef struct packed {
      logic pgm_dis;
      logic load;
      logic strobe;
      logic csn;
   } fuse_pins_t;

   localparam fuse_pins_t PINS_STANDBY = '{pgm_dis: 1'b1, load: 1'b0,
                                           strobe: 1'b0, csn: 1'b1};

   function automatic logic pins_read_mode(input fuse_pins_t p);
      return p.load & p.pgm_dis & ~p.csn;
   endfunction

endpackage

// File: rtl/fuse_ctrl_reg.sv
module fuse_ctrl_reg
   import fuse_regport_pkg::*;
#(
   parameter int FUSE_AW  = 10,
   parameter int ADDR_LSB = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [DATA_W-1:0]         wdata,
   output fuse_pins_t                pins,
   output logic [FUSE_AW-1:0]        fuse_addr,
   output logic                      fire,
   output logic [DATA_W-1:0]         rdata
);

   logic       err_q;
   fuse_pins_t pins_new;
   logic       bad_strobe;
   logic       unused_wd;

   assign unused_wd = ^wdata;

   always_comb begin
      pins_new.csn     = wdata[PIN_CSN_BIT];
      pins_new.strobe  = wdata[PIN_STB_BIT];
      pins_new.load    = wdata[PIN_LOAD_BIT];
      pins_new.pgm_dis = wdata[PIN_PGD_BIT];
   end

   assign bad_strobe = wr_en & pins_new.strobe & ~pins_read_mode(pins_new);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pins      <= PINS_STANDBY;
         fuse_addr <= '0;
         err_q     <= 1'b0;
      end else if (wr_en) begin
         pins      <= pins_new;
         fuse_addr <= wdata[ADDR_LSB +: FUSE_AW];
         if (bad_strobe)
            err_q <= 1'b1;
         else if (wdata[ERR_BIT])
            err_q <= 1'b0;
      end
   end

   assign fire = pins.strobe & pins_read_mode(pins);

   always_comb begin
      rdata                      = '0;
      rdata[PIN_CSN_BIT]         = pins.csn;
      rdata[PIN_STB_BIT]         = pins.strobe;
      rdata[PIN_LOAD_BIT]        = pins.load;
      rdata[PIN_PGD_BIT]         = pins.pgm_dis;
      rdata[ADDR_LSB +: FUSE_AW] = fuse_addr;
      rdata[ERR_BIT]             = err_q;
   end

   // R6
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wdata[PIN_STB_BIT] && wdata[PIN_CSN_BIT]) |=> rdata[ERR_BIT]);

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata[ERR_BIT] && !(wr_en && wdata[ERR_BIT])) |=> rdata[ERR_BIT]);

   // R9
   err_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wdata[ERR_BIT] && wdata[PIN_STB_BIT] && !wdata[PIN_LOAD_BIT])
      |=> rdata[ERR_BIT]);

   // R3
   no_fire_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[PIN_CSN_BIT] |-> !fire);

endmodule

// File: rtl/fuse_array_model.sv
module fuse_array_model
   import fuse_regport_pkg::*;
#(
   parameter int FUSE_AW = 10,
   parameter logic [(FUSE_BYTE_W << FUSE_AW)-1:0] FUSE_IMAGE = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [FUSE_AW-1:0]      rd_addr,
   output logic [FUSE_BYTE_W-1:0]  rd_data
);

   localparam int DEPTH = 1 << FUSE_AW;

   logic [FUSE_BYTE_W-1:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            cells[i] <= FUSE_IMAGE[i*FUSE_BYTE_W +: FUSE_BYTE_W];
      end else begin
         for (int i = 0; i < DEPTH; i++)
            cells[i] <= cells[i];
      end
   end

   assign rd_data = cells[rd_addr];

   // R11
   fuse_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(rd_addr) |-> $stable(rd_data));

endmodule

// File: rtl/fuse_dout_reg.sv
module fuse_dout_reg
   import fuse_regport_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fire,
   input  logic [FUSE_BYTE_W-1:0]  fuse_byte,
   output logic [FUSE_BYTE_W-1:0]  dout
);

   logic [FUSE_BYTE_W-1:0] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held_q <= '0;
      else if (fire)
         held_q <= fuse_byte;
   end

   assign dout = fire ? fuse_byte : held_q;

   // R5
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> (fire || $stable(dout)));

   // R3
   dout_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> dout == fuse_byte);

endmodule

// File: rtl/fuse_regport.sv
module fuse_regport
   import fuse_regport_pkg::*;
#(
   parameter int FUSE_AW  = 10,
   parameter int ADDR_LSB = 6,
   parameter int BUS_AW   = 3,
   parameter logic [(FUSE_BYTE_W << FUSE_AW)-1:0] FUSE_IMAGE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata
);

   localparam logic [BUS_AW-1:0] CTRL_OFS = BUS_AW'(0);
   localparam logic [BUS_AW-1:0] DOUT_OFS = BUS_AW'(4);

   generate
      if (ADDR_LSB < 4 || ADDR_LSB + FUSE_AW > ERR_BIT) begin : g_bad_field
         $error("fuse address field overlaps pin or error bits");
      end
      if (BUS_AW < 3) begin : g_bad_bus
         $error("bus offset too narrow for two word registers");
      end
   endgenerate

   fuse_pins_t             pins;
   logic [FUSE_AW-1:0]     fuse_addr;
   logic                   fire;
   logic [DATA_W-1:0]      ctrl_rdata;
   logic [FUSE_BYTE_W-1:0] fuse_byte;
   logic [FUSE_BYTE_W-1:0] dout;
   logic                   ctrl_wr;
   logic                   rd_act;
   logic                   unused_pins;

   assign unused_pins = ^{pins.load, pins.pgm_dis};
   assign ctrl_wr = bus_valid & bus_write & (bus_addr == CTRL_OFS);
   assign rd_act  = bus_valid & ~bus_write;

   fuse_ctrl_reg #(.FUSE_AW(FUSE_AW), .ADDR_LSB(ADDR_LSB)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ctrl_wr),
      .wdata     (bus_wdata),
      .pins      (pins),
      .fuse_addr (fuse_addr),
      .fire      (fire),
      .rdata     (ctrl_rdata)
   );

   fuse_array_model #(.FUSE_AW(FUSE_AW), .FUSE_IMAGE(FUSE_IMAGE)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (fuse_addr),
      .rd_data (fuse_byte)
   );

   fuse_dout_reg u_dout (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .fuse_byte (fuse_byte),
      .dout      (dout)
   );

   always_comb begin
      bus_rdata = '0;
      if (rd_act) begin
         if (bus_addr == CTRL_OFS)
            bus_rdata = ctrl_rdata;
         else if (bus_addr == DOUT_OFS)
            bus_rdata = {{(DATA_W-FUSE_BYTE_W){1'b0}}, dout};
      end
   end

   // R10
   dout_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act && bus_addr == DOUT_OFS) |-> bus_rdata[31:FUSE_BYTE_W] == '0);

   // R10
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_addr != CTRL_OFS && bus_addr != DOUT_OFS) |-> bus_rdata == '0);

   // R5
   strobe_low_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pins.strobe |-> !fire);

endmodule

// File: tb/sim_fuse_regport.sv
module sim_fuse_regport;

   localparam int AW = 10;
   localparam int DEPTH = 1 << AW;

   function automatic logic [7:0] img_byte(input int a);
      return 8'((a * 37) + (a >> 3) + 8'h5A);
   endfunction

   function automatic logic [DEPTH*8-1:0] mk_img();
      logic [DEPTH*8-1:0] v;
      v = '0;
      for (int a = 0; a < DEPTH; a++) v[a*8 +: 8] = img_byte(a);
      return v;
   endfunction

   localparam logic [DEPTH*8-1:0] IMG = mk_img();

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fuse_regport #(.FUSE_AW(AW), .ADDR_LSB(6), .BUS_AW(3), .FUSE_IMAGE(IMG)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1;
      n_chk++;
      if (bus_rdata !== exp) begin
         n_bad++;
         $display("FAIL %s off=%0h actual=%08h expected=%08h", req, a, bus_rdata, exp);
      end
      bus_valid = 1'b0;
   endtask

   function automatic logic [31:0] cw(input int a, input logic [3:0] pins);
      return (32'(a) << 6) | 32'(pins);
   endfunction

   task automatic t_reset();
      rd_chk(3'h0, 32'h0000_0009, "R1");
      rd_chk(3'h4, 32'h0, "R1");
   endtask

   task automatic t_ctrl_rw();
      wr(3'h0, 32'h7FFF_5A7C);
      rd_chk(3'h0, 32'h0000_5A4C, "R2");
      wr(3'h0, 32'h0000_0009);
      rd_chk(3'h0, 32'h0000_0009, "R2");
   endtask

   task automatic t_fetch(input int a);
      wr(3'h0, cw(a, 4'hC));
      wr(3'h0, cw(a, 4'hE));
      rd_chk(3'h4, {24'h0, img_byte(a)}, "R3 R11");
      wr(3'h0, cw(a, 4'hC));
      rd_chk(3'h4, {24'h0, img_byte(a)}, "R5");
   endtask

   task automatic t_follow();
      wr(3'h0, cw(200, 4'hE));
      rd_chk(3'h4, {24'h0, img_byte(200)}, "R4");
      wr(3'h0, cw(201, 4'hE));
      rd_chk(3'h4, {24'h0, img_byte(201)}, "R4");
      wr(3'h0, cw(201, 4'hC));
      wr(3'h0, 32'h0000_0009);
      rd_chk(3'h4, {24'h0, img_byte(201)}, "R5");
   endtask

   task automatic t_standby_strobe();
      wr(3'h0, cw(77, 4'hB));
      rd_chk(3'h4, {24'h0, img_byte(201)}, "R6");
      rd_chk(3'h0, 32'h8000_0000 | cw(77, 4'hB), "R6");
      wr(3'h0, 32'h0000_0009);
      rd_chk(3'h0, 32'h8000_0009, "R8");
      wr(3'h0, 32'h8000_0009);
      rd_chk(3'h0, 32'h0000_0009, "R8");
   endtask

   task automatic t_noload_strobe();
      wr(3'h0, cw(78, 4'hA));
      rd_chk(3'h4, {24'h0, img_byte(201)}, "R7");
      rd_chk(3'h0, 32'h8000_0000 | cw(78, 4'hA), "R7");
      wr(3'h0, 32'h8000_0009);
      wr(3'h0, cw(79, 4'h6));
      rd_chk(3'h4, {24'h0, img_byte(201)}, "R7");
      rd_chk(3'h0, 32'h8000_0000 | cw(79, 4'h6), "R7");
      wr(3'h0, 32'h8000_0009);
      rd_chk(3'h0, 32'h0000_0009, "R8");
   endtask

   task automatic t_prio();
      wr(3'h0, 32'h8000_000B);
      rd_chk(3'h0, 32'h8000_000B, "R9");
      wr(3'h0, 32'h8000_0009);
      rd_chk(3'h0, 32'h0000_0009, "R9");
   endtask

   task automatic t_unmapped();
      wr(3'h4, 32'hFFFF_FFFF);
      rd_chk(3'h4, {24'h0, img_byte(201)}, "R10");
      wr(3'h6, 32'h0000_0000);
      rd_chk(3'h0, 32'h0000_0009, "R10");
      rd_chk(3'h2, 32'h0, "R10");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctrl_rw();
      t_fetch(0);
      t_fetch(1023);
      t_fetch(512);
      t_fetch(5);
      t_follow();
      t_standby_strobe();
      t_noload_strobe();
      t_prio();
      t_unmapped();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule